// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block translates architectural register numbers into tags of a shared physical register file for a decode group of up to two instructions per cycle. It keeps three pieces of state. A speculative map gives the newest tag for every architectural register. A committed map gives the tag that holds each register's retired value. A circular free list holds the tags that are not in use. For each accepted instruction that writes a register, the unit takes a fresh tag from the free list. It also reports the physical tags of both sources and the tag that the destination was mapped to before this instruction.

The surrounding pipeline keeps the triple (architectural destination, new tag, previous tag) for each instruction. It hands that triple back through one of two ports. At retirement, the commit port moves the committed map to the new tag and releases the previous tag. No register value is copied. After a mispredict or trap, the undo port receives the squashed instructions one per cycle, youngest first. Each one puts the speculative map entry back to its previous tag and releases the new tag. A done strobe ends the undo sequence. A lookup port reads the committed map.

Top module: `phys_rename`

## Requirements
- R1: After reset, architectural register i maps to tag i in both maps. The free list hands out tags NARCH up to NPHYS-1 in increasing order. With the defaults this is 32 to 63.
- R2: Register 0 always translates to tag 0 and is never remapped. A slot that is invalid, has no destination, or names register 0 as its destination takes no tag from the free list, and its new-tag and previous-tag outputs read 0.
- R3: Each accepted slot that writes a register receives the tag at the head of the free list. Slot 0 takes the head first. Tags handed out in the same cycle are different from each other and are never 0.
- R4: The previous-tag output of a writing slot equals the speculative mapping of its destination just before this group.
- R5: After a group is accepted, later lookups of its destinations return the newly assigned tags.
- R6: In slot 1, a source equal to slot 0's destination reads slot 0's new tag. If both slots write the same register, slot 1's previous tag is slot 0's new tag, and slot 1's tag is the one left in the map.
- R7: Ready is low when the free list holds fewer tags than the group needs. While ready is low, no slot fires and no state changes. A group that needs no tags is accepted even when the free list is empty.
- R8: A commit entry writes the committed map at its register with its new tag, visible on the lookup port from the next cycle. It appends its previous tag to the tail of the free list. When a commit and an undo arrive in the same cycle, the commit's tag is appended first.
- R9: Each undo entry restores the speculative map at its register to the previous tag and appends the new tag to the free list. Ready stays low from the first undo entry up to and including the cycle that carries the done strobe.
- R10: Released tags are handed out again in the order in which they were released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Slot valid, bit s for slot s |
| in_has_dst | input | 2 | Slot writes a destination register |
| in_dst | input | 2x5 | Architectural destination per slot |
| in_src1 | input | 2x5 | First architectural source per slot |
| in_src2 | input | 2x5 | Second architectural source per slot |
| out_ready | output | 1 | Group can be accepted this cycle |
| out_fire | output | 2 | Slot accepted this cycle |
| out_new_tag | output | 2x6 | Newly assigned destination tag per slot |
| out_psrc1 | output | 2x6 | Physical tag of first source |
| out_psrc2 | output | 2x6 | Physical tag of second source |
| out_prev_tag | output | 2x6 | Previous mapping of the destination |
| cm_valid | input | 1 | Retire one writing instruction |
| cm_arch | input | 5 | Retiring destination register |
| cm_new_tag | input | 6 | Tag it was assigned |
| cm_old_tag | input | 6 | Tag it replaced, released now |
| un_valid | input | 1 | Undo one squashed writing instruction |
| un_arch | input | 5 | Squashed destination register |
| un_new_tag | input | 6 | Tag it was assigned, released now |
| un_old_tag | input | 6 | Tag to restore in the speculative map |
| un_done | input | 1 | Undo sequence complete |
| q_arch | input | 5 | Committed-map lookup register |
| q_tag | output | 6 | Committed tag of q_arch |

## Verification
The assertions check on every cycle the properties that depend only on the current group and the free-list occupancy. These are: register 0 translating to tag 0, distinct non-zero tags within a group, forwarding from slot 0 into slot 1, stalling on a short free list, the occupancy dropping by two on a full group, and the rename block during undo. Properties that span many cycles can only be shown by the bench scenarios. These are the identity map after reset, FIFO reuse of released tags, committed-map contents, exhaustion of the free list, and restoration of the speculative map after a full rollback. The bench compares every output against a reference model of the maps and the free queue.

// File: rtl/rn_pkg.sv
package rn_pkg;

   localparam int RN_SLOTS = 2;

   typedef enum logic {
      RN_RUN  = 1'b0,
      RN_UNDO = 1'b1
   } rn_mode_e;

   function automatic logic [1:0] rn_count2(input logic [1:0] v);
      return {1'b0, v[0]} + {1'b0, v[1]};
   endfunction

endpackage

// File: rtl/rn_maptable.sv
module rn_maptable #(
   parameter int NENT     = 32,
   parameter int TW       = 6,
   parameter int NRD      = 1,
   parameter int NWR      = 1,
   parameter bit PIN_ZERO = 1'b1,
   localparam int IW      = $clog2(NENT)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NRD-1:0][IW-1:0]   rd_idx,
   output logic [NRD-1:0][TW-1:0]   rd_tag,
   input  logic [NWR-1:0]           wr_en,
   input  logic [NWR-1:0][IW-1:0]   wr_idx,
   input  logic [NWR-1:0][TW-1:0]   wr_tag
);

   if (NENT > (1 << TW)) begin : g_bad_width
      $error("rn_maptable: tag width too small for identity reset");
   end

   logic [TW-1:0] ent [NENT];

   // later write port has priority
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NENT; i++) ent[i] <= TW'(i);
      end else begin
         for (int w = 0; w < NWR; w++) begin
            if (wr_en[w] && (!PIN_ZERO || wr_idx[w] != '0))
               ent[wr_idx[w]] <= wr_tag[w];
         end
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      if (PIN_ZERO) begin : g_pin
         assign rd_tag[r] = (rd_idx[r] == '0) ? '0 : ent[rd_idx[r]];
      end else begin : g_plain
         assign rd_tag[r] = ent[rd_idx[r]];
      end
   end

endmodule

// File: rtl/rn_freelist.sv
module rn_freelist #(
   parameter int NPHYS  = 64,
   parameter int NINIT  = 32,
   parameter int TW     = 6,
   localparam int PW    = $clog2(NPHYS),
   localparam int CW    = PW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           pop_n,
   output logic [1:0][TW-1:0]   head_tag,
   output logic [CW-1:0]        count,
   input  logic [1:0]           push_en,
   input  logic [1:0][TW-1:0]   push_tag
);

   if ((1 << PW) != NPHYS) begin : g_bad_depth
      $error("rn_freelist: NPHYS must be a power of two");
   end
   if (NINIT >= NPHYS) begin : g_bad_init
      $error("rn_freelist: NINIT must be below NPHYS");
   end

   logic [TW-1:0] mem [NPHYS];
   logic [PW-1:0] head, tail, tail_nx1;

   assign head_tag[0] = mem[head];
   assign head_tag[1] = mem[head + PW'(1)];
   assign tail_nx1    = push_en[0] ? tail + PW'(1) : tail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NPHYS; i++)
            mem[i] <= (i < NPHYS - NINIT) ? TW'(NINIT + i) : '0;
         head  <= '0;
         tail  <= PW'(NPHYS - NINIT);
         count <= CW'(NPHYS - NINIT);
      end else begin
         if (push_en[0]) mem[tail]     <= push_tag[0];
         if (push_en[1]) mem[tail_nx1] <= push_tag[1];
         head  <= head + PW'(pop_n);
         tail  <= tail + PW'(push_en[0]) + PW'(push_en[1]);
         count <= count - CW'(pop_n) + CW'(push_en[0]) + CW'(push_en[1]);
      end
   end

endmodule

// File: rtl/phys_rename.sv
module phys_rename
   import rn_pkg::*;
#(
   parameter int NARCH = 32,
   parameter int NPHYS = 64,
   localparam int AW   = $clog2(NARCH),
   localparam int TW   = $clog2(NPHYS),
   localparam int CW   = TW + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [RN_SLOTS-1:0]           in_valid,
   input  logic [RN_SLOTS-1:0]           in_has_dst,
   input  logic [RN_SLOTS-1:0][AW-1:0]   in_dst,
   input  logic [RN_SLOTS-1:0][AW-1:0]   in_src1,
   input  logic [RN_SLOTS-1:0][AW-1:0]   in_src2,
   output logic                          out_ready,
   output logic [RN_SLOTS-1:0]           out_fire,
   output logic [RN_SLOTS-1:0][TW-1:0]   out_new_tag,
   output logic [RN_SLOTS-1:0][TW-1:0]   out_psrc1,
   output logic [RN_SLOTS-1:0][TW-1:0]   out_psrc2,
   output logic [RN_SLOTS-1:0][TW-1:0]   out_prev_tag,
   input  logic                          cm_valid,
   input  logic [AW-1:0]                 cm_arch,
   input  logic [TW-1:0]                 cm_new_tag,
   input  logic [TW-1:0]                 cm_old_tag,
   input  logic                          un_valid,
   input  logic [AW-1:0]                 un_arch,
   input  logic [TW-1:0]                 un_new_tag,
   input  logic [TW-1:0]                 un_old_tag,
   input  logic                          un_done,
   input  logic [AW-1:0]                 q_arch,
   output logic [TW-1:0]                 q_tag
);

   if (RN_SLOTS != 2) begin : g_bad_slots
      $error("phys_rename: forwarding network is built for two slots");
   end
   if (NPHYS <= NARCH) begin : g_bad_pool
      $error("phys_rename: physical pool must exceed architectural count");
   end

   localparam int NRD = 3 * RN_SLOTS;
   localparam int NWR = RN_SLOTS + 1;

   rn_mode_e                   mode;
   logic [RN_SLOTS-1:0]        need;
   logic [1:0]                 need_cnt;
   logic [1:0][TW-1:0]         fl_head;
   logic [CW-1:0]              fl_count;
   logic [1:0]                 fl_pop;
   logic [NRD-1:0][AW-1:0]     sp_rd_idx;
   logic [NRD-1:0][TW-1:0]     sp_rd_tag;
   logic [NWR-1:0]             sp_wr_en;
   logic [NWR-1:0][AW-1:0]     sp_wr_idx;
   logic [NWR-1:0][TW-1:0]     sp_wr_tag;

   // per-slot translation with slot-0 forwarding into slot 1
   for (genvar s = 0; s < RN_SLOTS; s++) begin : g_slot
      logic [TW-1:0] t_s1, t_s2, t_pv;

      assign need[s] = in_valid[s] && in_has_dst[s] && (in_dst[s] != '0);
      assign sp_rd_idx[3*s]   = in_src1[s];
      assign sp_rd_idx[3*s+1] = in_src2[s];
      assign sp_rd_idx[3*s+2] = in_dst[s];

      if (s == 0) begin : g_lead
         assign t_s1 = sp_rd_tag[0];
         assign t_s2 = sp_rd_tag[1];
         assign t_pv = sp_rd_tag[2];
         assign out_new_tag[0] = need[0] ? fl_head[0] : '0;
      end else begin : g_trail
         logic hit1, hit2, hitd;
         assign hit1 = need[0] && (in_src1[s] == in_dst[0]);
         assign hit2 = need[0] && (in_src2[s] == in_dst[0]);
         assign hitd = need[0] && (in_dst[s]  == in_dst[0]);
         assign t_s1 = hit1 ? out_new_tag[0] : sp_rd_tag[3*s];
         assign t_s2 = hit2 ? out_new_tag[0] : sp_rd_tag[3*s+1];
         assign t_pv = hitd ? out_new_tag[0] : sp_rd_tag[3*s+2];
         assign out_new_tag[s] = !need[s] ? '0 :
                                 need[0]  ? fl_head[1] : fl_head[0];
      end

      assign out_psrc1[s]    = t_s1;
      assign out_psrc2[s]    = t_s2;
      assign out_prev_tag[s] = need[s] ? t_pv : '0;
      assign sp_wr_en[s]     = out_fire[s] && need[s];
      assign sp_wr_idx[s]    = in_dst[s];
      assign sp_wr_tag[s]    = out_new_tag[s];
   end

   // undo port is the highest-priority write
   assign sp_wr_en[RN_SLOTS]  = un_valid;
   assign sp_wr_idx[RN_SLOTS] = un_arch;
   assign sp_wr_tag[RN_SLOTS] = un_old_tag;

   assign need_cnt  = rn_count2(need);
   assign out_ready = (mode == RN_RUN) && !un_valid && (fl_count >= CW'(need_cnt));
   assign out_fire  = in_valid & {RN_SLOTS{out_ready}};
   assign fl_pop    = out_ready ? need_cnt : 2'd0;

   always_ff @(posedge clk) begin
      if (!rst_n)        mode <= RN_RUN;
      else if (un_done)  mode <= RN_RUN;
      else if (un_valid) mode <= RN_UNDO;
   end

   rn_maptable #(
      .NENT(NARCH), .TW(TW), .NRD(NRD), .NWR(NWR), .PIN_ZERO(1'b1)
   ) u_spec (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(sp_rd_idx), .rd_tag(sp_rd_tag),
      .wr_en(sp_wr_en), .wr_idx(sp_wr_idx), .wr_tag(sp_wr_tag)
   );

   rn_maptable #(
      .NENT(NARCH), .TW(TW), .NRD(1), .NWR(1), .PIN_ZERO(1'b1)
   ) u_commit (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(q_arch), .rd_tag(q_tag),
      .wr_en(cm_valid), .wr_idx(cm_arch), .wr_tag(cm_new_tag)
   );

   rn_freelist #(
      .NPHYS(NPHYS), .NINIT(NARCH), .TW(TW)
   ) u_free (
      .clk(clk), .rst_n(rst_n),
      .pop_n(fl_pop), .head_tag(fl_head), .count(fl_count),
      .push_en({un_valid, cm_valid}),
      .push_tag({un_new_tag, cm_old_tag})
   );

endmodule

// File: rtl/phys_rename_chk.sv
module phys_rename_chk #(
   parameter int NARCH = 32,
   parameter int NPHYS = 64,
   localparam int AW   = $clog2(NARCH),
   localparam int TW   = $clog2(NPHYS),
   localparam int CW   = TW + 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           in_valid,
   input logic [1:0]           in_has_dst,
   input logic [1:0][AW-1:0]   in_dst,
   input logic [1:0][AW-1:0]   in_src1,
   input logic [1:0][AW-1:0]   in_src2,
   input logic                 out_ready,
   input logic [1:0]           out_fire,
   input logic [1:0][TW-1:0]   out_new_tag,
   input logic [1:0][TW-1:0]   out_psrc1,
   input logic [1:0][TW-1:0]   out_psrc2,
   input logic                 cm_valid,
   input logic                 un_valid,
   input logic                 un_done,
   input logic [CW-1:0]        fl_count
);

   logic [1:0] c_need;
   logic [1:0] c_cnt;
   assign c_need[0] = in_valid[0] && in_has_dst[0] && (in_dst[0] != '0);
   assign c_need[1] = in_valid[1] && in_has_dst[1] && (in_dst[1] != '0);
   assign c_cnt     = {1'b0, c_need[0]} + {1'b0, c_need[1]};

   a_r2_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
      (in_src1[0] == '0) |-> (out_psrc1[0] == '0));

   a_r3_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire == 2'b11 && c_need == 2'b11) |-> (out_new_tag[0] != out_new_tag[1]));

   a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire[1] && c_need[1]) |-> (out_new_tag[1] != '0));

   a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (c_need[0] && in_src2[1] == in_dst[0]) |-> (out_psrc2[1] == out_new_tag[0]));

   a_r7_short_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_count < CW'(c_cnt)) |-> !out_ready);

   a_r7_pop_two: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && c_cnt == 2'd2 && !cm_valid && !un_valid)
      |=> (fl_count == $past(fl_count) - CW'(2)));

   a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
      un_valid |-> !out_ready);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (un_valid && !un_done) |=> !out_ready);

endmodule

bind phys_rename phys_rename_chk #(.NARCH(NARCH), .NPHYS(NPHYS)) u_chk (.*);

// File: tb/tb_phys_rename.sv
module tb_phys_rename;

   localparam int PER = 10;
   localparam int NA  = 32;
   localparam int NP  = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]       in_valid, in_has_dst;
   logic [1:0][4:0]  in_dst, in_src1, in_src2;
   logic             out_ready;
   logic [1:0]       out_fire;
   logic [1:0][5:0]  out_new_tag, out_psrc1, out_psrc2, out_prev_tag;
   logic             cm_valid, un_valid, un_done;
   logic [4:0]       cm_arch, un_arch, q_arch;
   logic [5:0]       cm_new_tag, cm_old_tag, un_new_tag, un_old_tag, q_tag;

   always #(PER/2) clk = ~clk;

   phys_rename dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_has_dst(in_has_dst), .in_dst(in_dst),
      .in_src1(in_src1), .in_src2(in_src2),
      .out_ready(out_ready), .out_fire(out_fire), .out_new_tag(out_new_tag),
      .out_psrc1(out_psrc1), .out_psrc2(out_psrc2), .out_prev_tag(out_prev_tag),
      .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_new_tag(cm_new_tag),
      .cm_old_tag(cm_old_tag),
      .un_valid(un_valid), .un_arch(un_arch), .un_new_tag(un_new_tag),
      .un_old_tag(un_old_tag), .un_done(un_done),
      .q_arch(q_arch), .q_tag(q_tag)
   );

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   // reference model
   int sm [NA];
   int cmm [NA];
   int fq [NP];
   int fh, ft, fc;
   int rob_a [512];
   int rob_n [512];
   int rob_o [512];
   int rh, rt;

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic fq_push(input int t);
      fq[ft] = t;
      ft = (ft + 1) % NP;
      fc++;
   endtask

   task automatic idle_inputs();
      in_valid = '0; in_has_dst = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
      cm_valid = 1'b0; cm_arch = '0; cm_new_tag = '0; cm_old_tag = '0;
      un_valid = 1'b0; un_arch = '0; un_new_tag = '0; un_old_tag = '0;
      un_done = 1'b0;
   endtask

   task automatic group(input string req,
                        input bit v0, input bit h0, input int d0, input int a0, input int b0,
                        input bit v1, input bit h1, input int d1, input int a1, input int b1);
      bit n0, n1, er;
      int e0, e1, pv0, pv1, s11, s21;
      @(negedge clk);
      in_valid = {v1, v0}; in_has_dst = {h1, h0};
      in_dst[0] = 5'(d0); in_src1[0] = 5'(a0); in_src2[0] = 5'(b0);
      in_dst[1] = 5'(d1); in_src1[1] = 5'(a1); in_src2[1] = 5'(b1);
      #1;
      n0 = v0 && h0 && d0 != 0;
      n1 = v1 && h1 && d1 != 0;
      er = fc >= (int'(n0) + int'(n1));
      chk(req, "ready", int'(out_ready), int'(er));
      chk(req, "fire", int'(out_fire), er ? int'({v1, v0}) : 0);
      e0 = 0; e1 = 0; pv0 = 0; pv1 = 0;
      if (er) begin
         if (n0) e0 = fq[fh];
         if (n1) e1 = n0 ? fq[(fh + 1) % NP] : fq[fh];
         if (n0) pv0 = sm[d0];
         if (n1) pv1 = (n0 && d1 == d0) ? e0 : sm[d1];
         s11 = (n0 && a1 == d0) ? e0 : sm[a1];
         s21 = (n0 && b1 == d0) ? e0 : sm[b1];
         if (v0) begin
            chk(req, "new0", int'(out_new_tag[0]), e0);
            chk(req, "src1_0", int'(out_psrc1[0]), sm[a0]);
            chk(req, "src2_0", int'(out_psrc2[0]), sm[b0]);
            chk(req, "prev0", int'(out_prev_tag[0]), pv0);
         end
         if (v1) begin
            chk(req, "new1", int'(out_new_tag[1]), e1);
            chk(req, "src1_1", int'(out_psrc1[1]), s11);
            chk(req, "src2_1", int'(out_psrc2[1]), s21);
            chk(req, "prev1", int'(out_prev_tag[1]), pv1);
         end
      end
      @(posedge clk);
      #1;
      if (er) begin
         if (n0) begin
            rob_a[rt] = d0; rob_n[rt] = e0; rob_o[rt] = pv0; rt++;
            sm[d0] = e0; fh = (fh + 1) % NP; fc--;
         end
         if (n1) begin
            rob_a[rt] = d1; rob_n[rt] = e1; rob_o[rt] = pv1; rt++;
            sm[d1] = e1; fh = (fh + 1) % NP; fc--;
         end
      end
      idle_inputs();
   endtask

   task automatic src_sweep(input string req);
      for (int a = 0; a < NA; a++)
         group(req, 1, 0, 0, a, a, 1, 0, 0, NA - 1 - a, (a + 5) % NA);
   endtask

   task automatic commit_sweep(input string req);
      for (int a = 0; a < NA; a++) begin
         @(negedge clk);
         q_arch = 5'(a);
         #1;
         chk(req, "committed", int'(q_tag), cmm[a]);
      end
   endtask

   task automatic commit_one();
      int a;
      a = rob_a[rh];
      @(negedge clk);
      cm_valid = 1'b1; cm_arch = 5'(a);
      cm_new_tag = 6'(rob_n[rh]); cm_old_tag = 6'(rob_o[rh]);
      q_arch = 5'(a);
      @(posedge clk);
      #1;
      cmm[a] = rob_n[rh];
      fq_push(rob_o[rh]);
      rh++;
      idle_inputs();
      chk("R8", "lookup after commit", int'(q_tag), cmm[a]);
   endtask

   task automatic undo_one();
      rt--;
      @(negedge clk);
      un_valid = 1'b1; un_arch = 5'(rob_a[rt]);
      un_new_tag = 6'(rob_n[rt]); un_old_tag = 6'(rob_o[rt]);
      in_valid = 2'b01;
      #1;
      chk("R9", "ready during undo", int'(out_ready), 0);
      chk("R9", "fire during undo", int'(out_fire), 0);
      @(posedge clk);
      #1;
      sm[rob_a[rt]] = rob_o[rt];
      fq_push(rob_n[rt]);
      idle_inputs();
   endtask

   initial begin
      idle_inputs();
      q_arch = '0;
      for (int i = 0; i < NA; i++) begin sm[i] = i; cmm[i] = i; end
      for (int i = 0; i < NP; i++) fq[i] = 0;
      for (int i = 0; i < NP - NA; i++) fq[i] = NA + i;
      fh = 0; ft = NP - NA; fc = NP - NA; rh = 0; rt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "ready after reset", int'(out_ready), 1);

      // R1: identity maps after reset
      src_sweep("R1");
      commit_sweep("R1");

      // R3, R6: first allocation, slot1 source forwarded from slot0
      group("R6", 1, 1, 5, 5, 6, 1, 1, 7, 5, 7);
      // R5: later lookups see new tags
      group("R5", 1, 0, 0, 5, 7, 1, 0, 0, 7, 5);
      // R6, R4: both slots write the same register
      group("R6", 1, 1, 3, 3, 3, 1, 1, 3, 3, 1);
      group("R6", 1, 0, 0, 3, 3, 0, 0, 0, 0, 0);
      // R2: register 0 destination and no destination take no tag
      group("R2", 1, 1, 0, 0, 9, 1, 0, 4, 0, 0);
      group("R2", 0, 1, 8, 0, 0, 0, 1, 9, 0, 0);
      // R3: only slot1 writes, takes the head
      group("R3", 0, 0, 0, 0, 0, 1, 1, 12, 12, 0);

      // R7: drain the free list
      for (int k = 0; fc >= 2; k++)
         group("R7", 1, 1, (k % 31) + 1, (k % 31) + 1, 2, 1, 1, ((k + 7) % 31) + 1, 1, (k % 31) + 1);
      if (fc == 1) begin
         group("R7", 1, 1, 10, 1, 2, 1, 1, 11, 3, 4);
         group("R7", 1, 1, 10, 10, 2, 0, 0, 0, 0, 0);
      end
      group("R7", 1, 1, 14, 1, 2, 0, 0, 0, 0, 0);
      group("R7", 0, 0, 0, 0, 0, 1, 1, 15, 15, 15);
      group("R7", 1, 0, 0, 4, 5, 1, 1, 0, 6, 7);
      src_sweep("R7");

      // R8: retire the oldest entries
      for (int k = 0; k < 4; k++) commit_one();
      commit_sweep("R8");

      // R10: released tags come back in release order
      group("R10", 1, 1, 20, 1, 2, 1, 1, 21, 20, 3);
      group("R10", 1, 1, 22, 21, 22, 0, 0, 0, 0, 0);

      // R9: roll back everything still in flight
      while (rt > rh) undo_one();
      @(negedge clk);
      un_done = 1'b1;
      #1;
      chk("R9", "ready on done cycle", int'(out_ready), 0);
      @(posedge clk);
      #1;
      idle_inputs();
      @(negedge clk);
      #1;
      chk("R9", "ready after done", int'(out_ready), 1);
      src_sweep("R9");

      // R10: tags released by undo are reused in order
      group("R10", 1, 1, 25, 25, 1, 1, 1, 26, 25, 26);
      group("R10", 1, 1, 27, 26, 27, 1, 1, 28, 27, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(PER * 150000);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule